// File: doc/BRIEF.md
# Pin-Edge Wakeup Controller with Settle Stall

This block decides when a halted core may run again. While the core runs, a halt request parks it. While parked, the block watches the serial receive line for one chosen transition. That transition is a falling edge when the edge select is high, which matches a start bit, and a rising edge when the edge select is low. Only a transition of the chosen kind, with the wakeup enable set, ends the halt.

The block does not release the core at once after a wakeup. It holds the core stalled for a fixed number of clock cycles, 256 by default, so that a restarting oscillator can settle. Software must allow for serial characters that arrive during this stall, because the core is not yet running. A sticky event flag records that a wakeup took place and stays set until software clears it.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `wake_settle_ctrl`

## Requirements
- R1: During and straight after reset, `core_run` is 1 and `wake_evt` is 0.
- R2: A `halt_req` seen high at a rising clock edge while the core runs drives `core_run` to 0 from that edge on. It stays 0 for as long as no wakeup occurs.
- R3: With `edge_fall_sel` = 1 only a high-to-low transition of `rx_pin` wakes the halted block. With `edge_fall_sel` = 0 only a low-to-high transition does. A transition in the other direction leaves the block halted with `wake_evt` at 0.
- R4: With `wake_en` = 0, no transition on `rx_pin` wakes the block.
- R5: `rx_pin` passes through a two-stage synchronizer. A qualifying change made between rising edges takes effect at the third rising edge after the change. Before that edge, `wake_evt` is still 0.
- R6: After a wakeup, `core_run` stays 0 for exactly SETTLE_CYCLES clock cycles and then returns to 1.
- R7: `wake_evt` is set at the wakeup edge. It stays set until a cycle with `evt_clr` high, and it reads 0 from the following edge.
- R8: A transition on `rx_pin` while the core runs is ignored: `wake_evt` stays 0 and `core_run` stays 1.
- R9: `halt_req` during the settle stall is ignored. The settle count restarts from zero on every entry to the stall, so a second halt and wakeup again gives a full SETTLE_CYCLES stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req | input | 1 | Request to halt the core |
| wake_en | input | 1 | Enables the receive line as wakeup source |
| edge_fall_sel | input | 1 | 1: falling edge wakes, 0: rising edge wakes |
| rx_pin | input | 1 | Asynchronous serial receive line being watched |
| evt_clr | input | 1 | Clears the wakeup event flag |
| core_run | output | 1 | 1: core may execute, 0: halted or settling |
| wake_evt | output | 1 | Sticky wakeup event flag |

## Verification
The delays follow the timing of the requirements. `core_run` falls one edge after `halt_req`. A pin change reaches `wake_evt` at the third edge. `core_run` comes back SETTLE_CYCLES edges after that, and the flag clear takes effect one edge after `evt_clr`. The bench drives inputs and samples outputs only at falling clock edges. For each delay it counts whole cycles from the stimulus. It checks the output at the last cycle where the old value is due and again at the first cycle where the new value is due. The sweep covers every combination of enable, edge select and transition direction on a short settle window.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } wake_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RESET_VAL;
        else if (g == 0) chain_q[g] <= async_in;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic fall_sel,
  output logic hit
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL;
    else        prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;
  assign fall = ~sig_in & prev_q;
  assign hit  = fall_sel ? fall : rise;
endmodule

// File: rtl/wake_settle_cnt.sv
module wake_settle_cnt #(
  parameter int CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && (cnt_q == LAST);
endmodule

// File: rtl/wake_settle_ctrl.sv
module wake_settle_ctrl #(
  parameter int   SETTLE_CYCLES = 256,
  parameter int   SYNC_STAGES   = 2,
  parameter logic RX_IDLE       = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic wake_en,
  input  logic edge_fall_sel,
  input  logic rx_pin,
  input  logic evt_clr,
  output logic core_run,
  output logic wake_evt
);
  import wake_pkg::*;

  wake_state_t state_q;
  logic rx_sync, edge_hit, wake_hit, settle_done, evt_q;

  wake_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(RX_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rx_pin), .sync_out(rx_sync)
  );

  wake_edge_det #(.RESET_VAL(RX_IDLE)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(rx_sync), .fall_sel(edge_fall_sel), .hit(edge_hit)
  );

  wake_settle_cnt #(.CYCLES(SETTLE_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(state_q == ST_SETTLE), .done(settle_done)
  );

  assign wake_hit = wake_en && edge_hit && (state_q == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      case (state_q)
        ST_RUN:    if (halt_req)    state_q <= ST_HALT;
        ST_HALT:   if (wake_hit)    state_q <= ST_SETTLE;
        ST_SETTLE: if (settle_done) state_q <= ST_RUN;
        default:                    state_q <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt_q <= 1'b0;
    else if (wake_hit) evt_q <= 1'b1;
    else if (evt_clr)  evt_q <= 1'b0;
  end

  assign core_run = (state_q == ST_RUN);
  assign wake_evt = evt_q;
endmodule

// File: rtl/wake_settle_ctrl_chk.sv
module wake_settle_ctrl_chk #(
  parameter int SETTLE_CYCLES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic halt_req,
  input logic evt_clr,
  input logic core_run,
  input logic wake_evt,
  input wake_pkg::wake_state_t state_q
);
  import wake_pkg::*;
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] stall_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stall_cnt <= '0;
    else if (state_q == ST_SETTLE) stall_cnt <= stall_cnt + 1'b1;
    else                           stall_cnt <= '0;
  end

  p_halt_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && halt_req) |=> !core_run);

  p_run_falls_on_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_run) |-> $past(halt_req));

  p_wake_only_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> ($past(state_q) == ST_HALT && !core_run));

  p_evt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !evt_clr) |=> wake_evt);

  p_settle_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (stall_cnt < CW'(SETTLE_CYCLES)));

  p_settle_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_SETTLE) |-> (stall_cnt == CW'(SETTLE_CYCLES)));

  p_settle_ignores_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |=> (state_q != ST_HALT));
endmodule

bind wake_settle_ctrl wake_settle_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .evt_clr(evt_clr),
  .core_run(core_run), .wake_evt(wake_evt), .state_q(state_q)
);

// File: tb/wake_settle_ctrl_tb_top.sv
module wake_settle_ctrl_tb_top;
  localparam int S = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, wake_en = 1'b0, edge_fall_sel = 1'b1, rx_pin = 1'b1, evt_clr = 1'b0;
  logic core_run, wake_evt;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  wake_settle_ctrl #(.SETTLE_CYCLES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_en(wake_en),
    .edge_fall_sel(edge_fall_sel), .rx_pin(rx_pin), .evt_clr(evt_clr),
    .core_run(core_run), .wake_evt(wake_evt)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic rx_level);
    @(negedge clk);
    rst_n = 1'b0; halt_req = 1'b0; evt_clr = 1'b0; rx_pin = rx_level;
    step(2);
    chk("R1 core_run in reset", core_run, 1'b1);
    chk("R1 wake_evt in reset", wake_evt, 1'b0);
    rst_n = 1'b1;
    step(4);
    chk("R1 core_run after reset", core_run, 1'b1);
    chk("R1 wake_evt after reset", wake_evt, 1'b0);
  endtask

  task automatic enter_halt();
    halt_req = 1'b1;
    step(1);
    halt_req = 1'b0;
    chk("R2 core_run after halt", core_run, 1'b0);
    step(4);
    chk("R2 still halted", core_run, 1'b0);
  endtask

  // wake by a matching falling edge; returns at the negedge after the wake edge
  task automatic fall_wake();
    wake_en = 1'b1; edge_fall_sel = 1'b1;
    rx_pin = 1'b0;
    step(2);
    chk("R5 no wake before third edge", wake_evt, 1'b0);
    step(1);
    chk("R5 wake_evt at third edge", wake_evt, 1'b1);
    chk("R6 stalled at wake", core_run, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Sweep: enable x edge select x transition direction
    for (int en = 0; en < 2; en++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int dfall = 0; dfall < 2; dfall++) begin
          logic woken;
          woken = (en == 1) && (sel == dfall);
          do_reset(dfall == 1 ? 1'b1 : 1'b0);
          wake_en = logic'(en); edge_fall_sel = logic'(sel);
          enter_halt();
          rx_pin = ~rx_pin;
          step(2);
          chk("R5 wake_evt before third edge", wake_evt, 1'b0);
          step(1);
          if (woken) begin
            chk("R3 matching edge wakes", wake_evt, 1'b1);
            chk("R6 stall begins", core_run, 1'b0);
            step(S - 1);
            chk("R6 still stalled at last settle cycle", core_run, 1'b0);
            step(1);
            chk("R6 runs after settle", core_run, 1'b1);
            step(5);
            chk("R7 flag sticky", wake_evt, 1'b1);
            evt_clr = 1'b1;
            step(1);
            evt_clr = 1'b0;
            chk("R7 flag cleared", wake_evt, 1'b0);
          end else begin
            chk((en == 0) ? "R4 disabled no wake" : "R3 wrong edge no wake", wake_evt, 1'b0);
            step(S + 3);
            chk((en == 0) ? "R4 stays halted" : "R3 stays halted", core_run, 1'b0);
            chk((en == 0) ? "R4 flag stays clear" : "R3 flag stays clear", wake_evt, 1'b0);
          end
        end
      end
    end

    // R8: edges while running are ignored
    do_reset(1'b1);
    wake_en = 1'b1; edge_fall_sel = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rx_pin = ~rx_pin;
      step(4);
      chk("R8 running edge no flag", wake_evt, 1'b0);
      chk("R8 running edge keeps run", core_run, 1'b1);
    end

    // R9: halt during settle ignored; count restarts on second entry
    do_reset(1'b1);
    enter_halt();
    fall_wake();
    step(2);
    halt_req = 1'b1;
    step(1);
    halt_req = 1'b0;
    step(S - 4);
    chk("R9 still settling", core_run, 1'b0);
    step(1);
    chk("R9 runs on time despite halt_req", core_run, 1'b1);
    step(3);
    chk("R9 stays running", core_run, 1'b1);
    rx_pin = 1'b1;
    step(4);
    evt_clr = 1'b1;
    step(1);
    evt_clr = 1'b0;
    enter_halt();
    fall_wake();
    step(S - 1);
    chk("R9 full stall on second entry", core_run, 1'b0);
    step(1);
    chk("R9 runs after second stall", core_run, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule